// File: doc/BRIEF.md
# Interrupt Expander Register Block

This block gathers up to sixteen peripheral interrupt lines and presents them to a host CPU through a small 16-bit register window. It drives one level-sensitive, active-high interrupt request. Each line passes through a two-flop synchroniser. A per-line edge tracker then turns every low-to-high transition into a one-cycle event pulse, and that pulse latches a sticky status bit. The status bit is latched whether or not the line is enabled.

The host reads the latched events and acknowledges them by writing ones to the status offset. It enables lines through a set-only offset and disables them through a clear-only offset, and it can read back the live synchronised line levels. The request output stays high while any latched event is also enabled. On the board this block serves, line 8 carries the Ethernet controller request and lines 10 and 11 carry the two external UART channels.

Each line has its own edge tracker with two states. LINE_IDLE means the synchronised line was last seen low. LINE_ACTIVE means it was last seen high. The transition IDLE→ACTIVE happens when the line is seen high, and it emits the event pulse. The transition ACTIVE→IDLE happens when the line is seen low, and it emits nothing. In every other case the tracker holds its state.

Top module: `irq_expander`

## Requirements
- R1: After reset the enable mask and latched status are all zero, and `irq_out` is low.
- R2: Byte offset 0x16 reads the latched status. Writing it clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: Byte offset 0x18 reads the live line state after the two-flop synchroniser. A change on `line_in` that is present at clock edge k appears in the read value after edge k+1.
- R4: Writing byte offset 0x1A sets every mask bit written as 1. Bits written as 0 are unaffected. Reading 0x1A returns the mask.
- R5: Writing byte offset 0x1C clears every mask bit written as 1. Bits written as 0 are unaffected. Reading 0x1C also returns the mask.
- R6: `irq_out` is high exactly when some bit is set in both the latched status and the mask.
- R7: A status bit is set one cycle after its synchronised line rises, whatever the mask holds. A line that stays high does not set the bit again after it is cleared.
- R8: When a rising edge and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Every other offset reads as zero, and writes to it change neither the mask nor the status.
- R10: With the lines steady, writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves the mask zero, the status zero and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 16 | Asynchronous peripheral interrupt lines, bit n is line n |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Level interrupt request to the CPU, active high |

## Verification
The collision that matters is an edge-detector event and a host acknowledge hitting the same status bit in one cycle. The bench provokes it by raising a line and then timing a write-one-to-clear so that it is sampled on the edge where the synchronised rise is latched. It judges the result by reading the status back and expecting the bit still set. Mask writes that coincide with new events are covered by a long stretch of random line activity mixed with random register writes. A behavioural model follows that stretch and compares the read data and `irq_out` on every clock.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int unsigned OFF_STATUS   = 'h16;
    localparam int unsigned OFF_LIVE     = 'h18;
    localparam int unsigned OFF_MASK_SET = 'h1A;
    localparam int unsigned OFF_MASK_CLR = 'h1C;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    logic seen_edge_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge_q <= 1'b0;
        else        seen_edge_q <= 1'b1;
    end

    AST_SYNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge_q |-> (stage_q[0] == $past(din))); // R3

endmodule

// File: rtl/irqx_edge_fsm.sv
module irqx_edge_fsm
    import irqx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    line_state_e state_q;
    line_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LINE_IDLE:   if (level)  state_nx = LINE_ACTIVE;
            LINE_ACTIVE: if (!level) state_nx = LINE_IDLE;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            LINE_IDLE:   rise = level;
            LINE_ACTIVE: rise = 1'b0;
        endcase
    end

    AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R7

endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise,
    input  logic [NUM_LINES-1:0] live,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] status_q,
    output logic [NUM_LINES-1:0] mask_q
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_LIVE   = ADDR_W'(OFF_LIVE);
    localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(OFF_MASK_SET);
    localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(OFF_MASK_CLR);

    logic                 clr_hit;
    logic                 set_hit;
    logic                 dis_hit;
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] status_d;
    logic [NUM_LINES-1:0] mask_d;

    assign wbits   = bus_wdata[NUM_LINES-1:0];
    assign clr_hit = bus_wr && (bus_addr == A_STATUS);
    assign set_hit = bus_wr && (bus_addr == A_MSET);
    assign dis_hit = bus_wr && (bus_addr == A_MCLR);

    // A new event is applied after the acknowledge, so it wins on a collision.
    always_comb begin
        status_d = status_q;
        if (clr_hit) status_d = status_d & ~wbits;
        status_d = status_d | rise;
    end

    always_comb begin
        mask_d = mask_q;
        if (set_hit) mask_d = mask_d | wbits;
        if (dis_hit) mask_d = mask_d & ~wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS) begin
            bus_rdata[NUM_LINES-1:0] = status_q;
        end else if (bus_addr == A_LIVE) begin
            bus_rdata[NUM_LINES-1:0] = live;
        end else if (bus_addr == A_MSET || bus_addr == A_MCLR) begin
            bus_rdata[NUM_LINES-1:0] = mask_q;
        end
    end

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_q) & ~status_q)) |-> $past(clr_hit)); // R2

    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((mask_q & $past(wbits)) == $past(wbits))); // R4

    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        dis_hit |=> ((mask_q & $past(wbits)) == '0)); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((status_q & $past(rise)) == $past(rise))); // R8

endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_out
);

    logic [NUM_LINES-1:0] live;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] mask_q;

    irqx_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (live)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irqx_edge_fsm u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .level (live[i]),
            .rise  (rise[i])
        );
    end

    irqx_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .live      (live),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_q  (status_q),
        .mask_q    (mask_q)
    );

    assign irq_out = |(status_q & mask_q);

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((status_q != '0) && (mask_q != '0))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !irq_out); // R1

endmodule

// File: tb/sim_irq_expander.sv
module sim_irq_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int vectors = 0;
    int fails = 0;
    bit live_cmp = 1'b0;

    always #4 clk = ~clk;

    irq_expander u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Behavioural reference: a two-deep sync pipe, the last seen level, status, mask.
    logic [15:0] m_s1 = '0, m_s2 = '0, m_seen = '0, m_stat = '0, m_mask = '0;

    always @(posedge clk) begin
        logic [15:0] ev, ns, nm;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_seen = '0; m_stat = '0; m_mask = '0;
        end else begin
            ev = m_s2 & ~m_seen;
            ns = m_stat;
            nm = m_mask;
            if (bus_wr && bus_addr == 8'h16) ns = ns & ~bus_wdata;
            ns = ns | ev;
            if (bus_wr && bus_addr == 8'h1A) nm = nm | bus_wdata;
            if (bus_wr && bus_addr == 8'h1C) nm = nm & ~bus_wdata;
            m_seen = m_s2; m_s2 = m_s1; m_s1 = line_in;
            m_stat = ns; m_mask = nm;
        end
    end

    function automatic logic [15:0] model_read(logic [7:0] a);
        case (a)
            8'h16:        return m_stat;
            8'h18:        return m_s2;
            8'h1A, 8'h1C: return m_mask;
            default:      return 16'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(logic [7:0] a);
        case (a)
            8'h16:   return "R2 status read";
            8'h18:   return "R3 live read";
            8'h1A:   return "R4 mask via set offset";
            8'h1C:   return "R5 mask via clear offset";
            default: return "R9 unused offset";
        endcase
    endfunction

    always @(negedge clk) begin
        if (live_cmp && rst_n) begin
            check(tag_for(bus_addr), bus_rdata, model_read(bus_addr));
            check("R6 irq_out", {15'h0, irq_out}, {15'h0, |(m_stat & m_mask)});
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        tick();
    endtask

    task automatic irq_is(logic exp, string tag);
        @(negedge clk);
        check(tag, {15'h0, irq_out}, {15'h0, exp});
        tick();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        live_cmp = 1'b1;

        // R1: reset state
        rd(8'h16, 16'h0, "R1 status after reset");
        rd(8'h1A, 16'h0, "R1 mask after reset");
        irq_is(1'b0, "R1 irq after reset");

        // R3 / R7: lines 8 and 10 rise while masked
        line_in = 16'h0500;
        tick(); tick();
        rd(8'h18, 16'h0500, "R3 live after sync");
        rd(8'h16, 16'h0500, "R7 latched while disabled");
        irq_is(1'b0, "R6 masked event quiet");

        // R4: enable line 8
        wr(8'h1A, 16'h0100);
        rd(8'h1A, 16'h0100, "R4 mask set");
        irq_is(1'b1, "R6 enabled event drives irq");

        // R2: acknowledge line 8, zero write leaves status unchanged
        wr(8'h16, 16'h0100);
        rd(8'h16, 16'h0400, "R2 w1c clears only written bit");
        irq_is(1'b0, "R6 irq drops after ack");
        wr(8'h16, 16'h0000);
        rd(8'h16, 16'h0400, "R2 zero write no effect");
        repeat (4) tick();
        rd(8'h16, 16'h0400, "R7 held line no re-latch");

        // R5: clear some mask bits
        wr(8'h1A, 16'hFFFF);
        wr(8'h1C, 16'h00F0);
        rd(8'h1C, 16'hFF0F, "R5 mask clear");
        rd(8'h1A, 16'hFF0F, "R4 mask readback");
        irq_is(1'b1, "R6 line 10 enabled");

        // R9: unused offsets
        wr(8'h00, 16'hFFFF);
        wr(8'h1E, 16'hFFFF);
        wr(8'h17, 16'hFFFF);
        rd(8'h00, 16'h0000, "R9 unused reads zero");
        rd(8'h1E, 16'h0000, "R9 unused reads zero");
        rd(8'h1A, 16'hFF0F, "R9 mask untouched");
        rd(8'h16, 16'h0400, "R9 status untouched");

        // R8: edge and acknowledge on line 3 in the same cycle
        line_in = line_in | 16'h0008;
        tick(); tick();
        bus_addr = 8'h16; bus_wdata = 16'h0008; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
        rd(8'h16, 16'h0408, "R8 event wins over ack");

        // Random activity compared every cycle
        for (int n = 0; n < 400; n++) begin
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 7));
            if (n % 3 == 0) line_in = 16'($urandom);
            case (pick)
                3'd0: wr(8'h16, 16'($urandom));
                3'd1: wr(8'h1A, 16'($urandom));
                3'd2: wr(8'h1C, 16'($urandom));
                3'd3: wr(8'h20, 16'($urandom));
                3'd4: begin bus_addr = 8'h18; tick(); end
                default: begin bus_addr = 8'h16; tick(); end
            endcase
        end

        // R10: disable all and clear all with steady lines
        repeat (4) tick();
        wr(8'h1C, 16'hFFFF);
        wr(8'h16, 16'hFFFF);
        rd(8'h1C, 16'h0000, "R10 mask all clear");
        rd(8'h16, 16'h0000, "R10 status all clear");
        irq_is(1'b0, "R10 irq low");

        live_cmp = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule